// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller with CAS-before-RAS Refresh

This controller connects a synchronous host request port to a 1M x 16 extended-data-out DRAM. The host offers one request at a time through a valid/ready handshake. A request carries a 20-bit word address, a write flag, two byte-lane enables and write data. The controller splits the address into a 10-bit row and a 10-bit column and puts them on a shared address bus one after the other. It drives the row strobe, a separate column strobe for each byte lane, the write enable and the output enable. Read data comes back with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row is served by a column cycle alone, with no new row activation. A request to a different row closes the page first. A free-running timer raises a refresh demand at a fixed cycle interval. When the current access ends, that demand wins over new host requests. It is served as a CAS-before-RAS cycle, and the controller precharges the row first if a page is open. All timing intervals are whole clock cycles set by parameters.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive), the data drivers are off, rdata_valid is low and req_ready is high.
- R2: req_addr[19:10] is on dram_a when the row strobe falls for an access, and req_addr[9:0] is on dram_a when the column strobes fall, so each written word is read back from the same location.
- R3: dram_cas_n[0] strobes the lower byte DQ[7:0] and is driven when req_be[0] is set. dram_cas_n[1] strobes the upper byte DQ[15:8] and is driven when req_be[1] is set. A request with req_be of 00 is served as a full word.
- R4: During a read column cycle write enable is high and output enable is low. rdata is sampled RD_LAT cycles after the column strobes fall and is flagged by a single-cycle rdata_valid. Bytes of disabled lanes read as zero.
- R5: A write uses the early form. Write enable is low and the data drivers are on from the cycle before the column strobes fall until they rise. Output enable stays high.
- R6: A request to the open row is accepted while the page is held open. It is served with the column strobes rising and falling again and no new row activation.
- R7: Each time the row strobe rises, it stays high for at least T_RP cycles before it falls again. This covers page misses and refresh.
- R8: A refresh drives both column strobes low with the row strobe high for T_CSR cycles and write enable high. It then holds the row strobe low for T_RAS_REF cycles, after which the row strobe rises.
- R9: While a refresh is pending no new request is accepted. Two consecutive refresh starts are never more than REF_INTERVAL+T_RCD+T_CAS+T_RP+T_CSR+4 cycles apart, whether the host is busy or idle.
- R10: req_ready is high only when no refresh is pending and either no row is open or the request targets the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper 10 bits |
| req_be | input | 2 | Byte enables, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| rdata_valid | output | 1 | One-cycle read data strobe |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, bit 0 lower |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The assertions check the strobe rules on every cycle. Output enable may only fall in a read column cycle. Write enable must lead any write column strobe. Write enable stays high while a column strobe is low ahead of the row strobe. The data drivers follow write enable. rdata_valid is a single pulse. A counter checks the gap between refreshes. The bench runs the DRAM model and host sweeps. These show what no single cycle can: byte-lane merging, the address split, the read sample latency, row activation counts on page hits, precharge lengths and the refresh pulse widths.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CSR        = 1,
  parameter int T_RAS_REF    = 3,
  parameter int RD_LAT       = 2,
  parameter int REF_INTERVAL = 3120,
  parameter int CNT_W        = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [ROW_W+COL_W-1:0]    req_addr,
  input  logic [DATA_W/8-1:0]       req_be,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rdata_valid,
  output logic [ROW_W-1:0]          dram_a,
  output logic                      dram_ras_n,
  output logic [DATA_W/8-1:0]       dram_cas_n,
  output logic                      dram_we_n,
  output logic                      dram_oe_n,
  output logic [DATA_W-1:0]         dram_dq_out,
  output logic                      dram_dq_oe,
  input  logic [DATA_W-1:0]         dram_dq_in
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LANES = DATA_W / 8;
  localparam int REF_W = $clog2(REF_INTERVAL);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_CAS, S_PAGE, S_PRE, S_REFC, S_REFR
  } st_t;

  st_t                st, nxt;
  logic [CNT_W-1:0]   cnt;
  logic [REF_W-1:0]   ref_cnt;
  logic               ref_pend;
  logic [ROW_W-1:0]   open_row;
  logic [COL_W-1:0]   col_q;
  logic               we_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  lane_mask;

  wire [ROW_W-1:0] req_row  = req_addr[ROW_W+COL_W-1:COL_W];
  wire             page_hit = (st == S_PAGE) && (req_row == open_row);
  wire             accept   = req_valid && req_ready;
  wire             rd_smp   = (st == S_CAS) && !we_q && (cnt == CNT_W'(RD_LAT - 1));
  wire             ref_tick = (ref_cnt == REF_W'(REF_INTERVAL - 1));

  assign req_ready = !ref_pend && ((st == S_IDLE) || page_hit);

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE: if (ref_pend) nxt = S_REFC; else if (accept) nxt = S_ROW;
      S_ROW:  if (cnt == CNT_W'(T_RCD - 1)) nxt = S_COL;
      S_COL:  nxt = S_CAS;
      S_CAS:  if (cnt == CNT_W'(T_CAS - 1)) nxt = S_PAGE;
      S_PAGE: if (ref_pend || (req_valid && !accept)) nxt = S_PRE;
              else if (accept) nxt = S_COL;
      S_PRE:  if (cnt == CNT_W'(T_RP - 1)) nxt = S_IDLE;
      S_REFC: if (cnt == CNT_W'(T_CSR - 1)) nxt = S_REFR;
      S_REFR: if (cnt == CNT_W'(T_RAS_REF - 1)) nxt = S_PRE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb
    for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{be_q[i]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ref_cnt     <= '0;
      ref_pend    <= 1'b0;
      open_row    <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= (nxt != st) ? '0 : cnt + CNT_W'(1);
      ref_cnt <= ref_tick ? '0 : ref_cnt + REF_W'(1);
      if (nxt == S_REFC && st != S_REFC) ref_pend <= 1'b0;
      if (ref_tick) ref_pend <= 1'b1;
      rdata_valid <= rd_smp;
      if (rd_smp) rdata <= dram_dq_in & lane_mask;
      if (accept) begin
        open_row <= req_row;
        col_q    <= req_addr[COL_W-1:0];
        we_q     <= req_we;
        be_q     <= (req_be == '0) ? '1 : req_be;
        wdata_q  <= req_wdata;
      end
    end
  end

  assign dram_ras_n  = !(st inside {S_ROW, S_COL, S_CAS, S_PAGE, S_REFR});
  assign dram_cas_n  = (st == S_CAS) ? ~be_q :
                       (st == S_REFC || st == S_REFR) ? '0 : '1;
  assign dram_we_n   = !(we_q && (st == S_COL || st == S_CAS));
  assign dram_oe_n   = !(!we_q && st == S_CAS);
  assign dram_dq_oe  = we_q && (st == S_COL || st == S_CAS);
  assign dram_dq_out = wdata_q;
  assign dram_a      = (st == S_COL || st == S_CAS) ? ROW_W'(col_q) : open_row;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int LANES = 2,
  parameter int BOUND = 3200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rdata_valid,
  input logic             dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic             dram_dq_oe
);
  timeunit 1ns;
  timeprecision 100ps;

  logic        ras_q;
  logic [31:0] gap;
  wire         cbr_start = ras_q && !dram_ras_n && (dram_cas_n != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      gap   <= '0;
    end else begin
      ras_q <= dram_ras_n;
      gap   <= cbr_start ? '0 : gap + 32'd1;
    end
  end

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && dram_cas_n == '1) |-> (dram_oe_n && !dram_dq_oe));

  a_r4_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (!dram_ras_n && dram_we_n && dram_cas_n != '1));

  a_r4_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  a_r5_we_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $past(dram_cas_n) == '1 && dram_cas_n != '1 && !dram_we_n)
      |-> !$past(dram_we_n));

  a_r5_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> !dram_we_n);

  a_r8_cbr_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && dram_cas_n != '1) |-> dram_we_n);

  a_r9_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= 32'(BOUND));

  a_r10_ready_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_cas_n == '1));

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .LANES(DATA_W / 8),
  .BOUND(REF_INTERVAL + T_RCD + T_CAS + T_RP + T_CSR + 4)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rdata_valid(rdata_valid),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
  .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_CSR = 1, T_RAS_REF = 3, RD_LAT = 2;
  localparam int REF_INTERVAL = 300;
  localparam int BOUND = REF_INTERVAL + T_RCD + T_CAS + T_RP + T_CSR + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rdata_valid;
  logic [15:0] rdata;
  logic [9:0]  dram_a;
  logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [1:0]  dram_cas_n;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = '0;

  always #2.5 clk = ~clk;

  edo_dram_ctrl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CSR(T_CSR),
    .T_RAS_REF(T_RAS_REF), .RD_LAT(RD_LAT), .REF_INTERVAL(REF_INTERVAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errs = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural DRAM model, sampled on the falling clock edge
  int          cyc = 0;
  logic [15:0] mem [int];
  logic [9:0]  mrow = '0, mcol = '0;
  logic        p_ras = 1'b1, p_we = 1'b1;
  logic [1:0]  p_cas = 2'b11;
  int act_n = 0, ref_n = 0;
  int ras_rise = 0, last_ref = 0, csr_cyc = 0, cas_cyc = 0, ref_fall = 0;
  bit rise_seen = 0, in_ref = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 2'b11; p_we = 1'b1; last_ref = cyc;
    end else begin
      if (p_ras && !dram_ras_n) begin
        if (rise_seen) chk(cyc - ras_rise >= T_RP, "R7", "row precharge cycles", cyc - ras_rise, T_RP);
        if (dram_cas_n == 2'b11) begin
          act_n++;
          mrow = dram_a;
        end else begin
          ref_n++;
          chk(dram_we_n == 1'b1, "R8", "write enable in refresh", dram_we_n, 1);
          chk(cyc - csr_cyc == T_CSR, "R8", "cas-before-ras setup", cyc - csr_cyc, T_CSR);
          chk(cyc - last_ref <= BOUND, "R9", "refresh gap", cyc - last_ref, BOUND);
          last_ref = cyc;
          in_ref = 1;
          ref_fall = cyc;
        end
      end
      if (!p_ras && dram_ras_n) begin
        ras_rise = cyc;
        rise_seen = 1;
        if (in_ref) begin
          chk(cyc - ref_fall == T_RAS_REF, "R8", "refresh row low cycles", cyc - ref_fall, T_RAS_REF);
          in_ref = 0;
        end
      end
      if (dram_ras_n && p_cas == 2'b11 && dram_cas_n != 2'b11) csr_cyc = cyc;
      if (!dram_ras_n && p_cas == 2'b11 && dram_cas_n != 2'b11) begin
        mcol = dram_a;
        cas_cyc = cyc;
        if (!dram_we_n) begin
          logic [15:0] w;
          int k;
          chk(!p_we, "R5", "write enable ahead of cas", p_we, 0);
          chk(dram_dq_oe && dram_oe_n, "R5", "drive on and oe high", {dram_dq_oe, dram_oe_n}, 2'b11);
          k = int'({mrow, mcol});
          w = mem.exists(k) ? mem[k] : 16'h0;
          for (int l = 0; l < 2; l++)
            if (!dram_cas_n[l]) w[8*l +: 8] = dram_dq_out[8*l +: 8];
          mem[k] = w;
        end
      end
      if (rdata_valid) chk(cyc - cas_cyc == RD_LAT, "R4", "read sample latency", cyc - cas_cyc, RD_LAT);
      begin
        logic [15:0] r;
        int k2;
        k2 = int'({mrow, mcol});
        r = mem.exists(k2) ? mem[k2] : 16'h0;
        for (int l = 0; l < 2; l++)
          dram_dq_in[8*l +: 8] = (!dram_ras_n && !dram_oe_n && !dram_cas_n[l]) ? r[8*l +: 8] : 8'h00;
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    end
  end

  function automatic logic [9:0] row_of(int i);
    return 10'((i * 341 + 5) % 1024);
  endfunction
  function automatic logic [9:0] col_of(int i);
    return 10'((i * 131) % 1024);
  endfunction
  function automatic logic [15:0] pat1(int r, int c);
    return 16'(r * 4093 + c * 257 + 16'h3c00);
  endfunction
  function automatic logic [15:0] pat2(int r, int c);
    return ~pat1(r, c) ^ 16'h1234;
  endfunction
  function automatic logic [15:0] expect_word(int r, int c);
    return (c % 2 == 0) ? {pat1(r, c)[15:8], pat2(r, c)[7:0]}
                        : {pat2(r, c)[15:8], pat1(r, c)[7:0]};
  endfunction

  task automatic host(input bit we, input logic [19:0] addr, input logic [1:0] be,
                      input logic [15:0] wd, input bit miss_chk, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = wd;
    #1;
    if (miss_chk) chk(!req_ready, "R10", "ready on page miss", req_ready, 0);
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    rd = '0;
    if (!we) begin
      do @(negedge clk); while (!rdata_valid);
      rd = rdata;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R9 watchdog: actual=%0d cycles expected completion earlier", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int a0, f0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n, "R1", "strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rdata_valid && req_ready, "R1", "drive/valid/ready after reset",
        {dram_dq_oe, rdata_valid, req_ready}, 3'b001);

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        host(1'b1, {row_of(r), col_of(c)}, 2'b11, pat1(r, c), 1'b0, rd);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        host(1'b1, {row_of(r), col_of(c)}, (c % 2 == 1) ? 2'b10 : 2'b01, pat2(r, c), 1'b0, rd);
    host(1'b1, {10'd9, 10'd9}, 2'b00, 16'hbeef, 1'b0, rd);

    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++) begin
        host(1'b0, {row_of(r), col_of(c)}, 2'b11, 16'h0, 1'b0, rd);
        chk(rd == expect_word(r, c), "R2", "merged word readback", rd, expect_word(r, c));
      end
    host(1'b0, {10'd9, 10'd9}, 2'b11, 16'h0, 1'b0, rd);
    chk(rd == 16'hbeef, "R3", "empty enables write as word", rd, 16'hbeef);

    for (int c = 0; c < 8; c++) begin
      host(1'b0, {row_of(1), col_of(c)}, 2'b01, 16'h0, 1'b0, rd);
      chk(rd == {8'h00, expect_word(1, c)[7:0]}, "R4", "lower lane read", rd, {8'h00, expect_word(1, c)[7:0]});
      host(1'b0, {row_of(1), col_of(c)}, 2'b10, 16'h0, 1'b0, rd);
      chk(rd == {expect_word(1, c)[15:8], 8'h00}, "R3", "upper lane read", rd, {expect_word(1, c)[15:8], 8'h00});
    end

    host(1'b0, {row_of(0), col_of(0)}, 2'b11, 16'h0, 1'b0, rd);
    a0 = act_n; f0 = ref_n;
    host(1'b0, {row_of(2), col_of(0)}, 2'b11, 16'h0, 1'b0, rd);
    host(1'b0, {row_of(2), col_of(1)}, 2'b11, 16'h0, 1'b0, rd);
    chk(rd == expect_word(2, 1), "R6", "page hit data", rd, expect_word(2, 1));
    chk((ref_n == f0) ? (act_n - a0 == 1) : (act_n - a0 >= 1 && act_n - a0 <= 1 + ref_n - f0),
        "R6", "row activations for two same-row reads", act_n - a0, 1);

    host(1'b0, {row_of(3), col_of(0)}, 2'b11, 16'h0, 1'b0, rd);
    host(1'b0, {row_of(0), col_of(3)}, 2'b11, 16'h0, 1'b1, rd);
    chk(rd == expect_word(0, 3), "R7", "data after page miss", rd, expect_word(0, 3));

    f0 = ref_n;
    repeat (3 * REF_INTERVAL) @(negedge clk);
    chk(ref_n - f0 >= 2, "R8", "refreshes while idle", ref_n - f0, 2);
    chk(ref_n >= 3, "R9", "total refreshes", ref_n, 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule